// File: doc/BRIEF.md
# Programmable Clock Ratio Generator

This block derives three clock-enable pulse trains from a single base clock: one for the processor core, one for the system bus and one for the peripheral domain. Nothing is gated. Every downstream register stays on the base clock and qualifies its updates with the matching enable. Each train is divided down from the base clock by a ratio, and a 3-bit code in a frequency control register picks that ratio from a fixed, non-uniform table.

Software reaches the control register through a simple write strobe and a combinational read port. A write always stores its value for readback. The dividers only switch to the newly written codes when the write carries the lock-enable flag. A second storage register shares the port and only holds data. A divider never changes ratio in the middle of a period. It picks up a new ratio when it reaches its next terminal count, so every pulse interval equals either the old period or the new one.

Top module: `clk_ratio_gen`

## Requirements
- R1: After reset the control register reads 0x0E0A and the storage register reads 0x0000. Under these reset codes the core divides by 1, the bus by 2 and the peripheral by 4.
- R2: Control bits [8:6] set the core ratio. Codes 0 through 7 give 1, 2, 3, 4, 5, 8, 8, 8.
- R3: Control bits [5:3] set the bus ratio, using the same table as the core field.
- R4: Control bits [2:0] set the peripheral ratio. Codes 0 through 7 give 2, 3, 4, 6, 8, 8, 8, 8.
- R5: A control write whose bit 10 is 0 updates the readback value and leaves all three ratios unchanged.
- R6: For a ratio N greater than 1, an enable is high for exactly one base cycle in every N. For a ratio of 1 the enable stays high.
- R7: A divider loads a new ratio only at its terminal count, which is the cycle in which its enable is high. The interval that is already running finishes at the old ratio.
- R8: With reg_sel = 0, rd_data shows the last value written to the control register, including codes that saturate to 8. With reg_sel = 1 it shows the last value written to the storage register.
- R9: In the first cycle after reset is released, all three enables are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 for control, 1 for storage |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the selected register |
| cpu_en | output | 1 | Core clock enable |
| bus_en | output | 1 | Bus clock enable |
| per_en | output | 1 | Peripheral clock enable |

## Verification
Two events can land on the same base-clock edge: a control write that carries the lock-enable flag, and a divider's terminal-count reload. In that case the reload still uses the old ratio, and the new ratio begins at the following terminal count. The bench provokes this by sweeping every code for all three fields, with writes spaced so that they fall on every phase of each divider, many of them exactly on a reload edge. A behavioural reference model with integer countdowns is compared with all three enables and the readback on every cycle, so a ratio applied one interval early or late appears as a mismatched pulse.

// File: rtl/crg_pkg.sv
package crg_pkg;
    localparam int FIELD_W = 3;
    localparam int RATIO_W = 4;
    typedef logic [RATIO_W-1:0] ratio_t;

    // core and bus table
    function automatic ratio_t core_ratio(input logic [FIELD_W-1:0] code);
        case (code)
            3'd0:    return ratio_t'(1);
            3'd1:    return ratio_t'(2);
            3'd2:    return ratio_t'(3);
            3'd3:    return ratio_t'(4);
            3'd4:    return ratio_t'(5);
            default: return ratio_t'(8);
        endcase
    endfunction

    // peripheral table
    function automatic ratio_t per_ratio(input logic [FIELD_W-1:0] code);
        case (code)
            3'd0:    return ratio_t'(2);
            3'd1:    return ratio_t'(3);
            3'd2:    return ratio_t'(4);
            3'd3:    return ratio_t'(6);
            default: return ratio_t'(8);
        endcase
    endfunction
endpackage

// File: rtl/crg_div.sv
module crg_div #(
    parameter int  CNT_W     = 3,
    parameter bit  PER_TABLE = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [crg_pkg::FIELD_W-1:0] code,
    output logic                        en
);
    import crg_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    ratio_t  ratio;

    generate
        if (PER_TABLE) begin : g_per
            assign ratio = per_ratio(code);
        end else begin : g_core
            assign ratio = core_ratio(code);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) begin
            st_d.cnt = CNT_W'(ratio - ratio_t'(1));
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en = (st_q.cnt == '0);
endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen #(
    parameter int              DW      = 16,
    parameter int              PLL_BIT = 10,
    parameter logic [DW-1:0]   CTL_RST = 16'h0E0A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          reg_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          cpu_en,
    output logic          bus_en,
    output logic          per_en
);
    localparam int NDIV  = 3;
    localparam int FW    = crg_pkg::FIELD_W;
    localparam int CODEW = NDIV * FW;
    localparam int CNT_W = 3;

    typedef struct packed {
        logic [DW-1:0]    ctl;
        logic [DW-1:0]    aux;
        logic [CODEW-1:0] act;
    } crg_st_t;

    crg_st_t st_d, st_q;

    logic [DW-1:0] ctl_q;
    logic [FW-1:0] code_cpu, code_bus, code_per;
    logic [NDIV-1:0] en_vec;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (!reg_sel) begin
                st_d.ctl = wr_data;
                if (wr_data[PLL_BIT]) begin
                    st_d.act = wr_data[CODEW-1:0];
                end
            end else begin
                st_d.aux = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl <= CTL_RST;
            st_q.aux <= '0;
            st_q.act <= CTL_RST[CODEW-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < NDIV; g++) begin : g_div
            crg_div #(
                .CNT_W     (CNT_W),
                .PER_TABLE (g == NDIV-1)
            ) i_div (
                .clk   (clk),
                .rst_n (rst_n),
                .code  (st_q.act[(NDIV-1-g)*FW +: FW]),
                .en    (en_vec[g])
            );
        end
    endgenerate

    assign ctl_q    = st_q.ctl;
    assign code_cpu = st_q.act[2*FW +: FW];
    assign code_bus = st_q.act[FW +: FW];
    assign code_per = st_q.act[0 +: FW];
    assign rd_data  = reg_sel ? st_q.aux : st_q.ctl;
    assign cpu_en   = en_vec[0];
    assign bus_en   = en_vec[1];
    assign per_en   = en_vec[2];
endmodule

// File: rtl/crg_checker.sv
module crg_checker #(
    parameter int DW      = 16,
    parameter int PLL_BIT = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          reg_sel,
    input logic [DW-1:0] wr_data,
    input logic [DW-1:0] ctl_q,
    input logic [2:0]    code_cpu,
    input logic [2:0]    code_bus,
    input logic [2:0]    code_per,
    input logic          cpu_en,
    input logic          bus_en,
    input logic          per_en
);
    // R5
    no_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && !wr_data[PLL_BIT]) |=>
            ($stable(code_cpu) && $stable(code_bus) && $stable(code_per)));

    // R8
    ctl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel) |=> (ctl_q == $past(wr_data)));

    // R6
    per_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_en |=> !per_en);

    // R2
    cpu_div1_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_cpu == 3'd0 && $past(code_cpu) == 3'd0 && $past(cpu_en)) |-> cpu_en);

    // R3
    bus_div2_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && code_bus == 3'd1) |=> !bus_en);
endmodule

bind clk_ratio_gen crg_checker i_crg_checker (.*);

// File: tb/test_clk_ratio_gen.sv
module test_clk_ratio_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        cpu_en, bus_en, per_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // behavioural reference
    int core_tab[8] = '{1, 2, 3, 4, 5, 8, 8, 8};
    int per_tab[8]  = '{2, 3, 4, 6, 8, 8, 8, 8};
    int rem[3];
    int ratio[3];
    int m_ctl, m_aux;

    always #5 clk = ~clk;

    clk_ratio_gen i_clk_ratio_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data),
        .cpu_en(cpu_en), .bus_en(bus_en), .per_en(per_en)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = 16'h0E0A; m_aux = 0;
            ratio[0] = 1; ratio[1] = 2; ratio[2] = 4;
            for (int i = 0; i < 3; i++) rem[i] = 0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (rem[i] == 0) rem[i] = ratio[i] - 1;
                else rem[i] = rem[i] - 1;
            end
            if (wr_en) begin
                if (!reg_sel) begin
                    m_ctl = wr_data;
                    if (wr_data[10]) begin
                        ratio[0] = core_tab[wr_data[8:6]];
                        ratio[1] = core_tab[wr_data[5:3]];
                        ratio[2] = per_tab[wr_data[2:0]];
                    end
                end else begin
                    m_aux = wr_data;
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 R6 R7 cpu_en", cpu_en, rem[0] == 0);
            check("R3 R6 R7 bus_en", bus_en, rem[1] == 0);
            check("R4 R6 R7 per_en", per_en, rem[2] == 0);
            check("R8 rd_data", rd_data, reg_sel ? m_aux : m_ctl);
        end
    end

    task automatic wr(input logic sel, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; reg_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // cycles between two consecutive rising enables of one output
    task automatic period(input int idx, output int p);
        logic prev;
        int cnt;
        cnt = 0;
        do begin
            @(negedge clk);
        end while (!(idx == 0 ? cpu_en : idx == 1 ? bus_en : per_en));
        do begin
            @(negedge clk);
            cnt++;
        end while (!(idx == 0 ? cpu_en : idx == 1 ? bus_en : per_en));
        prev = 1'b0;
        p = cnt + int'(prev);
    endtask

    initial begin
        int p;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        // R1 reset state
        check("R1 ctl reset", rd_data, 16'h0E0A);
        reg_sel = 1'b1; #1;
        check("R1 aux reset", rd_data, 0);
        reg_sel = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R9 all enables high first cycle
        check("R9 enables", {cpu_en, bus_en, per_en}, 3'b111);
        period(2, p); check("R1 per /4", p, 4);
        period(1, p); check("R1 bus /2", p, 2);
        // R5 write without lock bit
        wr(1'b0, 16'h00DB);
        idle(2);
        period(1, p); check("R5 bus kept /2", p, 2);
        period(2, p); check("R5 per kept /4", p, 4);
        // R6 ratio 1 is continuous
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); check("R6 cpu /1 high", cpu_en, 1);
        end
        // R4 peripheral /6
        wr(1'b0, 16'h0403);
        idle(10);
        period(2, p); check("R4 per /6", p, 6);
        // R8 storage register
        wr(1'b1, 16'hA5C3);
        reg_sel = 1'b1; idle(3); reg_sel = 1'b0;
        // sweep every code on all fields, with varying write phase (R2 R3 R4 R7)
        for (int c = 0; c < 8; c++) begin
            wr(1'b0, 16'(16'h0400 | (c << 6) | (((c + 3) % 8) << 3) | ((7 - c) % 8)));
            idle(17 + c);
        end
        for (int c = 0; c < 8; c++) begin
            wr(1'b0, 16'(16'h0400 | (c << 6) | (c << 3) | c));
            idle(c + 1);
            wr(1'b0, 16'(16'h0000 | (((c + 1) % 8) << 6)));
            idle(20);
        end
        // R8 saturated codes read back verbatim
        wr(1'b0, 16'h07FF);
        idle(24);
        @(negedge clk);
        check("R8 ctl saturated readback", rd_data, 16'h07FF);
        period(0, p); check("R2 cpu saturated /8", p, 8);
        period(2, p); check("R4 per saturated /8", p, 8);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule